// File: doc/BRIEF.md
# Smart Card Slot Power Sequencer

This block orders the power-up and power-down of one smart card slot. The host starts a card session by driving an active-low activate command low and ends it by driving it high. Between those two events the block enables the card supply regulator, checks that the supply came up, opens I/O reception, starts the card clock and then passes the host reset level through to the card. Every delay is counted on a slow internal tick of about 1.5 MHz. Only the short voltage-select window is counted in system clock cycles.

A session ends in one of two ways: the host releases the command, or a problem occurs. The problems are overcurrent, a low card supply, a lost logic supply and card removal. In every case the block steps the card signals down in the same fixed order. Faults are reported to the status logic. The card voltage is chosen when the command falls and is then held for the whole session. A new session can start only after the previous one has fully wound down and the command has gone high again.

Top module: `card_seq`

## Requirements
- R1: Outside a session, reg_en_o, io_en_o, clk_en_o and crst_o are low, and vcode_o is 2'b00. The same holds during reset.
- R2: A falling act_n_i starts a session only if all of these hold: card_in_i is high, lsup_ok_i is high, and lsup_ok_i has stayed high for HOLD_TK ticks. A fall without all three is ignored.
- R3: HOLD_TK is the supply-settle interval. CHK_TK ticks after reg_en_o rises, csup_ok_i must be high. If it is not, fault_o goes high, io_en_o never rises and the shutdown ordering runs. fault_o clears when a new session starts.
- R4: After a passed supply check, io_en_o rises IO_TK ticks later. clk_en_o then rises at least CK_TK ticks after io_en_o.
- R5: While hrst_i is high, clk_en_o stays low. The clock is started only once hrst_i is low.
- R6: The voltage code is decided when act_n_i falls and is held, unchanged, while reg_en_o is high. The codes are:
  - 2'b11 (5 V): vhi_i is high at the fall and does not fall during the window.
  - 2'b10 (3 V): vhi_i has been low for more than SEL_CYC clock cycles.
  - 2'b01 (1.8 V): vhi_i falls within SEL_CYC cycles before or after the command fall.
- R7: During a session, any of these starts shutdown: act_n_i high, over_i high, csup_ok_i low after the supply check, lsup_ok_i low, or card_in_i low. fault_o is set only for the over_i, csup_ok_i and lsup_ok_i causes.
- R8: Shutdown takes four steps, each after its own tick count, at one output change per cycle:
  - crst_o goes low D1_TK ticks after the trigger;
  - clk_en_o goes low D2_TK ticks later;
  - io_en_o goes low D3_TK ticks later;
  - reg_en_o goes low D4_TK ticks later.
- R9: Once shutdown is complete, act_n_i must go high before a new falling edge is accepted. While it stays low, reg_en_o stays low.
- R10: Once the clock runs, crst_o follows hrst_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle pulse at about 1.5 MHz |
| act_n_i | input | 1 | Host activate command, active low |
| hrst_i | input | 1 | Host reset level for the card |
| vhi_i | input | 1 | Host voltage select |
| card_in_i | input | 1 | Card present |
| lsup_ok_i | input | 1 | Logic supply valid |
| csup_ok_i | input | 1 | Card supply valid |
| over_i | input | 1 | Card overcurrent |
| reg_en_o | output | 1 | Regulator enable |
| vcode_o | output | 2 | Card voltage code |
| io_en_o | output | 1 | I/O reception enable |
| clk_en_o | output | 1 | Card clock gate |
| crst_o | output | 1 | Card reset |
| fault_o | output | 1 | Fault report |

## Verification
The host releasing the command and a fault can land in the same clock cycle, which raises the question of whether the fault is still reported. The bench drives act_n_i high and over_i high on the same edge. It expects fault_o set and the usual four-step shutdown spacing. Random sessions also place card removal and supply loss at the point where the session is running.

// File: rtl/card_seq.sv
module card_seq #(
  parameter int HOLD_TK = 1501,
  parameter int CHK_TK  = 300,
  parameter int IO_TK   = 3,
  parameter int CK_TK   = 2,
  parameter int D1_TK   = 2,
  parameter int D2_TK   = 13,
  parameter int D3_TK   = 2,
  parameter int D4_TK   = 2,
  parameter int SEL_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       act_n_i,
  input  logic       hrst_i,
  input  logic       vhi_i,
  input  logic       card_in_i,
  input  logic       lsup_ok_i,
  input  logic       csup_ok_i,
  input  logic       over_i,
  output logic       reg_en_o,
  output logic [1:0] vcode_o,
  output logic       io_en_o,
  output logic       clk_en_o,
  output logic       crst_o,
  output logic       fault_o
);
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CMAX = mx(mx(mx(CHK_TK, IO_TK), mx(CK_TK, D1_TK)),
                           mx(mx(D2_TK, D3_TK), mx(D4_TK, SEL_CYC)));
  localparam int CW = $clog2(CMAX + 1);
  localparam int HW = $clog2(HOLD_TK + 1);
  localparam int AW = $clog2(SEL_CYC + 2);

  typedef enum logic [3:0] {IDLE, SEL, PWR, IOW, CKW, ON, DR, DC, DI, DP, DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic [AW-1:0] age;
  logic          act_q, vhi_q, v18, hi0;

  wire ready    = lsup_ok_i && (hold == HW'(HOLD_TK));
  wire act_fall = act_q & ~act_n_i;
  wire vfall    = vhi_q & ~vhi_i;
  wire in_sess  = st inside {SEL, PWR, IOW, CKW, ON};
  wire chk_vcc  = st inside {IOW, CKW, ON};
  wire bad      = over_i | ~lsup_ok_i | (chk_vcc & ~csup_ok_i);
  wire stop     = bad | act_n_i | ~card_in_i;
  wire zero     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; hold <= '0; age <= AW'(SEL_CYC + 1);
      act_q <= 1'b1; vhi_q <= 1'b1; v18 <= 1'b0; hi0 <= 1'b1;
      reg_en_o <= 1'b0; vcode_o <= 2'b00; io_en_o <= 1'b0;
      clk_en_o <= 1'b0; crst_o <= 1'b0; fault_o <= 1'b0;
    end else begin
      act_q <= act_n_i;
      vhi_q <= vhi_i;
      if (!lsup_ok_i) hold <= '0;
      else if (tick_i && hold != HW'(HOLD_TK)) hold <= hold + 1'b1;
      if (vfall) age <= '0;
      else if (age != AW'(SEL_CYC + 1)) age <= age + 1'b1;

      if (st == SEL) cnt <= zero ? cnt : cnt - 1'b1;
      else if (tick_i && !zero) cnt <= cnt - 1'b1;

      if (in_sess && stop) begin
        st <= DR; cnt <= CW'(D1_TK); fault_o <= bad;
      end else begin
        case (st)
          IDLE: if (act_fall && card_in_i && ready) begin
            st <= SEL; cnt <= CW'(SEL_CYC); fault_o <= 1'b0;
            hi0 <= vhi_i;
            v18 <= ~vhi_i & (vfall | (age <= AW'(SEL_CYC)));
          end
          SEL: begin
            if (vfall) v18 <= 1'b1;
            if (zero) begin
              reg_en_o <= 1'b1;
              vcode_o  <= (v18 | vfall) ? 2'b01 : (hi0 ? 2'b11 : 2'b10);
              st <= PWR; cnt <= CW'(CHK_TK);
            end
          end
          PWR: if (zero) begin
            if (csup_ok_i) begin st <= IOW; cnt <= CW'(IO_TK); end
            else begin st <= DR; cnt <= CW'(D1_TK); fault_o <= 1'b1; end
          end
          IOW: if (zero) begin io_en_o <= 1'b1; st <= CKW; cnt <= CW'(CK_TK); end
          CKW: if (zero && !hrst_i) begin clk_en_o <= 1'b1; st <= ON; end
          ON:  crst_o <= hrst_i;
          DR:  if (zero) begin crst_o <= 1'b0; st <= DC; cnt <= CW'(D2_TK); end
          DC:  if (zero) begin clk_en_o <= 1'b0; st <= DI; cnt <= CW'(D3_TK); end
          DI:  if (zero) begin io_en_o <= 1'b0; st <= DP; cnt <= CW'(D4_TK); end
          DP:  if (zero) begin reg_en_o <= 1'b0; vcode_o <= 2'b00; st <= DONE; end
          DONE: if (act_n_i) st <= IDLE;
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r4_clk_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> io_en_o);
  a_r4_io_needs_reg: assert property (@(posedge clk) disable iff (!rst_n)
    io_en_o |-> reg_en_o);
  a_r10_crst_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
    crst_o |-> clk_en_o);
  a_r1_code_off: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en_o |-> vcode_o == 2'b00);
  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en_o && $past(reg_en_o)) |-> $stable(vcode_o));
  a_r5_clk_after_rst_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> $past(!hrst_i));
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_en_o ^ $past(reg_en_o), io_en_o ^ $past(io_en_o),
                clk_en_o ^ $past(clk_en_o), crst_o ^ $past(crst_o)}) <= 1);
endmodule

// File: tb/sim_card_seq.sv
module sim_card_seq;
  localparam int TKP = 4, HOLD = 20, CHK = 10, IOD = 3, CKD = 2;
  localparam int D1 = 2, D2 = 6, D3 = 2, D4 = 2, WIN = 8;

  logic clk = 0, rst_n = 0, tick = 0, act_n = 1, hrst = 0, vhi = 1;
  logic card_in = 1, lsup = 1, vcc_ok = 0, over = 0, rgood = 1;
  logic reg_en, io_en, clk_en, crst, fault;
  logic [1:0] vcode;
  int tk = 0, nchk = 0, nbad = 0, phase = 0;

  card_seq #(.HOLD_TK(HOLD), .CHK_TK(CHK), .IO_TK(IOD), .CK_TK(CKD), .D1_TK(D1),
             .D2_TK(D2), .D3_TK(D3), .D4_TK(D4), .SEL_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .act_n_i(act_n), .hrst_i(hrst),
    .vhi_i(vhi), .card_in_i(card_in), .lsup_ok_i(lsup), .csup_ok_i(vcc_ok),
    .over_i(over), .reg_en_o(reg_en), .vcode_o(vcode), .io_en_o(io_en),
    .clk_en_o(clk_en), .crst_o(crst), .fault_o(fault));

  always #5 clk = ~clk;
  always @(negedge clk) begin
    phase <= (phase == TKP - 1) ? 0 : phase + 1;
    tick  <= (phase == 0);
  end
  always @(posedge clk) begin
    if (tick) tk <= tk + 1;
    vcc_ok <= reg_en & rgood;
  end

  task automatic chk(input string r, input int a, input int e);
    nchk++;
    if (a != e) begin nbad++; $display("FAIL %s actual=%0d expected=%0d", r, a, e); end
  endtask
  task automatic rng(input string r, input int a, input int lo, input int hi);
    nchk++;
    if (a < lo || a > hi) begin
      nbad++; $display("FAIL %s actual=%0d expected=%0d..%0d", r, a, lo, hi);
    end
  endtask
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  function automatic logic sig(input int w);
    case (w)
      0: return reg_en;
      1: return io_en;
      2: return clk_en;
      default: return crst;
    endcase
  endfunction
  task automatic waitv(input int w, input logic v, output int t);
    t = -100000;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (sig(w) == v) begin t = tk; break; end
    end
  endtask
  function automatic int ecode(input int m);
    return (m == 0) ? 3 : (m == 1) ? 2 : 1;
  endfunction
  function automatic int efault(input int tr);
    return (tr == 1 || tr == 3 || tr == 4 || tr == 5) ? 1 : 0;
  endfunction

  task automatic run(input int m, input bit rhi, input int tr);
    int t0, t1, t2, t3, t4;
    logic [1:0] held;
    act_n = 1; cyc(4);
    case (m)
      0, 3: begin vhi = 1; cyc(20); end
      1: begin vhi = 0; cyc(30); end
      default: begin vhi = 1; cyc(20); vhi = 0; cyc(3); end
    endcase
    hrst = rhi; act_n = 0;
    if (m == 3) begin cyc(3); vhi = 0; end
    waitv(0, 1, t1);
    chk("R6 voltage code", vcode, ecode(m));
    chk("R3 fault cleared at start", fault, 0);
    waitv(1, 1, t2);
    rng("R4 supply check then io enable", t2 - t1, CHK + IOD, CHK + IOD + 3);
    if (rhi) begin
      cyc(40); chk("R5 clock held while host reset high", clk_en, 0); hrst = 0;
    end
    waitv(2, 1, t3);
    if (!rhi) rng("R4 io to clock gap", t3 - t2, CKD, CKD + 3);
    else chk("R5 clock starts after host reset low", clk_en, 1);
    hrst = 1; cyc(2); chk("R10 card reset follows high", crst, 1);
    hrst = 0; cyc(2); chk("R10 card reset follows low", crst, 0);
    hrst = 1; cyc(2);
    held = vcode; vhi = ~vhi; cyc(3);
    chk("R6 code latched", vcode, held);
    t0 = tk;
    case (tr)
      0: act_n = 1;
      1: over = 1;
      2: card_in = 0;
      3: rgood = 0;
      4: lsup = 0;
      default: begin act_n = 1; over = 1; end
    endcase
    waitv(3, 0, t1); rng("R8 card reset low first", t1 - t0, D1, D1 + 3);
    waitv(2, 0, t2); rng("R8 clock low second", t2 - t1, D2, D2 + 3);
    waitv(1, 0, t3); rng("R8 io low third", t3 - t2, D3, D3 + 3);
    waitv(0, 0, t4); rng("R8 supply off last", t4 - t3, D4, D4 + 3);
    chk("R7 fault report", fault, efault(tr));
    if (!act_n) begin cyc(30); chk("R9 no restart while command low", reg_en, 0); end
    over = 0; card_in = 1; rgood = 1; act_n = 1;
    if (tr == 4) begin lsup = 1; cyc((HOLD + 3) * TKP); end
  endtask

  initial begin
    int t;
    bit seen;
    int unsigned s;
    s = $urandom(32'd2024);
    cyc(5);
    chk("R1 reset reg_en", reg_en, 0); chk("R1 reset clk_en", clk_en, 0);
    chk("R1 reset io_en", io_en, 0); chk("R1 reset crst", crst, 0);
    chk("R1 reset vcode", vcode, 0);
    rst_n = 1; cyc(8);
    act_n = 0; cyc(50); chk("R2 blocked during supply hold", reg_en, 0);
    act_n = 1; cyc((HOLD + 3) * TKP);
    card_in = 0; act_n = 0; cyc(50); chk("R2 no card no start", reg_en, 0);
    act_n = 1; card_in = 1; cyc(4);
    rgood = 0; vhi = 1; act_n = 0;
    waitv(0, 1, t);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (io_en) seen = 1;
      if (!reg_en) break;
    end
    chk("R3 io never enabled on bad supply", seen, 0);
    chk("R3 fault on bad supply", fault, 1);
    chk("R1 code off after session", vcode, 0);
    act_n = 1; rgood = 1; cyc(4);
    run(0, 0, 0); run(1, 1, 1); run(2, 0, 2); run(3, 1, 3); run(0, 0, 4);
    run(1, 0, 5);
    for (int i = 0; i < 20; i++) run($urandom % 4, 1'($urandom % 2), $urandom % 6);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #1_900_000;
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule